// File: doc/BRIEF.md
# Byte-Wide FPGA Configuration Master

This block loads a configuration image into an FPGA target through an 8-bit parallel slave port. A one-cycle `start` pulse, together with a byte count, begins a load. The block first pulses the target's program line. It then waits until the target stops reporting init and busy. Next it frames the transfer: write enable goes on, then chip select, and the configuration clock is parked high.

Image bytes arrive on a valid/ready stream. Each byte is placed on the data bus for a setup phase. The configuration clock then goes low and comes back high, and the target captures the byte on that rising edge. When the busy check is built in, a byte that leaves the target busy is followed by extra clock pulses until busy clears, and the next byte waits for that.

After the last byte, chip select is released, then write. The clock keeps pulsing until the target reports done, and `load_ok` then pulses. Each wait is bounded: settling after program, a busy stall, and the wait for done. If any of them runs too long, the block raises a one-cycle abort toward the target and ends the load with `load_fail`. The default limit is 10 ms at a 50 MHz system clock.

Top module: `cfg_par_loader`

## Requirements
- R1: While reset is held and after it is released with no start, every output (`s_ready`, `cfg_prog`, `cfg_cs`, `cfg_wr`, `cfg_clk`, `cfg_d`, `cfg_abort`, `load_ok`, `load_fail`) is 0.
- R2: A `start` pulse seen while idle raises `cfg_prog` for exactly PROG_CYC cycles, with `cfg_cs` and `cfg_wr` low. A `start` pulse during a running load has no effect: `cfg_prog` does not rise again and the load completes normally.
- R3: After `cfg_prog` falls, `cfg_wr` stays low until both `cfg_init` and `cfg_busy` have been seen low.
- R4: `cfg_wr` rises exactly one cycle before `cfg_cs` rises. When the first byte is requested, `cfg_clk` is already high.
- R5: Exactly `byte_count` bytes are transferred, in stream order. Each byte is presented on `cfg_d` and taken by the target on one falling-then-rising pulse of `cfg_clk`, with chip select and write high.
- R6: `cfg_d` changes only while `cfg_clk` is high. It holds from before each falling edge until after the next rising edge.
- R7: With BUSY_CHK=1, when `cfg_busy` is high after a byte's rising edge, the block issues extra `cfg_clk` pulses and requests no new byte until `cfg_busy` is seen low. Each stall pulse is one extra rising edge.
- R8: After the last byte, `cfg_cs` falls exactly one cycle before `cfg_wr` falls.
- R9: After the framing is released, `cfg_clk` pulses until `cfg_done` is seen high. `load_ok` then pulses for one cycle. The number of pulses equals the number the target needed.
- R10: A timeout raises `cfg_abort` and `load_fail` together for one cycle, with `cfg_cs` and `cfg_wr` low. The timed waits are settling, a busy stall and the wait for done. For settling, abort follows TMO_CYC+1 cycles of `cfg_prog` low.
- R11: A load with `byte_count` 0 requests no byte, still frames and releases, and waits for done.
- R12: `s_ready` is high only while a byte is owed and the port is framed with `cfg_clk` high. No byte beyond `byte_count` is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a load when idle |
| byte_count | input | CNT_W | Number of image bytes, sampled with `start` |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | DATA_W | Stream byte |
| s_ready | output | 1 | Stream byte accepted when high together with `s_valid` |
| cfg_prog | output | 1 | Program (target reset) request, active high |
| cfg_cs | output | 1 | Target chip select, active high |
| cfg_wr | output | 1 | Target write enable, active high |
| cfg_clk | output | 1 | Configuration clock to the target |
| cfg_d | output | DATA_W | Configuration data bus |
| cfg_init | input | 1 | Target still initialising, active high |
| cfg_busy | input | 1 | Target busy, active high |
| cfg_done | input | 1 | Target configured, active high |
| cfg_abort | output | 1 | One-cycle abort strobe on timeout |
| load_ok | output | 1 | One-cycle pulse: load finished with done |
| load_fail | output | 1 | One-cycle pulse: load ended on a timeout |

## Verification
The bench builds the block with HALF=2, PROG_CYC=3, TMO_CYC=40 and CNT_W=8, with the busy check on. At these values every timeout path fits in a few dozen cycles, so the exact settle-timeout distance (41 cycles) can be counted directly. The short limits also make the stall and done-wait aborts reachable. The bench sweeps byte counts 0 to 6 with both a continuous stream and a gapped one. It adds stalls of known length and a delayed settle, and it computes the expected edge counts arithmetically from the number of bytes and the pulses the target model asks for.

// File: rtl/cfg_par_pkg.sv
package cfg_par_pkg;
   typedef enum logic [4:0] {
      ST_IDLE,
      ST_PROG,
      ST_SETTLE,
      ST_WR_ON,
      ST_CS_ON,
      ST_PARK,
      ST_REQ,
      ST_SETUP,
      ST_LOW,
      ST_HIGH,
      ST_BSY_CHK,
      ST_STALL_LO,
      ST_STALL_HI,
      ST_CS_OFF,
      ST_WR_OFF,
      ST_DONE_CHK,
      ST_DONE_LO,
      ST_DONE_HI,
      ST_OK,
      ST_FAIL
   } cfg_state_e;
endpackage

// File: rtl/cfg_phase_tick.sv
module cfg_phase_tick #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic last
);
   localparam int PW = (HALF < 2) ? 1 : $clog2(HALF);

   if (HALF < 1) begin : g_bad_half
      $error("cfg_phase_tick: HALF must be at least 1");
   end

   logic [PW-1:0] cnt_q;

   assign last = (cnt_q == PW'(HALF - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr)     cnt_q <= '0;
      else if (!last)   cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
   parameter int LIMIT = 500000
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   output logic [$clog2(LIMIT+1)-1:0]   count,
   output logic                         expired
);
   localparam int TW = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("cfg_wait_timer: LIMIT must be at least 1");
   end

   logic [TW-1:0] cnt_q;

   assign count   = cnt_q;
   assign expired = (cnt_q == TW'(LIMIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (clr)      cnt_q <= '0;
      else if (!expired) cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/cfg_byte_left.sv
module cfg_byte_left #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             zero
);
   if (CNT_W < 1) begin : g_bad_w
      $error("cfg_byte_left: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] left_q;

   assign zero = (left_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            left_q <= '0;
      else if (load)         left_q <= load_val;
      else if (dec && !zero) left_q <= left_q - 1'b1;
   end
endmodule

// File: rtl/cfg_par_loader.sv
module cfg_par_loader
   import cfg_par_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int DATA_W   = 8,
   parameter int HALF     = 2,       // configuration clock half-period, system cycles
   parameter int PROG_CYC = 8,       // program pulse width, system cycles
   parameter int TMO_CYC  = 500000,  // 10 ms at 50 MHz
   parameter bit BUSY_CHK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  byte_count,
   input  logic              s_valid,
   input  logic [DATA_W-1:0] s_data,
   output logic              s_ready,
   output logic              cfg_prog,
   output logic              cfg_cs,
   output logic              cfg_wr,
   output logic              cfg_clk,
   output logic [DATA_W-1:0] cfg_d,
   input  logic              cfg_init,
   input  logic              cfg_busy,
   input  logic              cfg_done,
   output logic              cfg_abort,
   output logic              load_ok,
   output logic              load_fail
);
   localparam int TW = $clog2(TMO_CYC + 1);

   if (PROG_CYC < 1 || PROG_CYC > TMO_CYC) begin : g_bad_prog
      $error("cfg_par_loader: PROG_CYC must lie in 1..TMO_CYC");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("cfg_par_loader: DATA_W must be at least 1");
   end

   cfg_state_e        state_q, state_d;
   logic              ph_last, ph_clr;
   logic              tm_clr, tm_exp;
   logic [TW-1:0]     tm_cnt;
   logic              left_zero, cnt_load, cnt_dec;
   logic              busy_gate;
   logic [DATA_W-1:0] d_q;
   logic              accept;

   // busy checking variant
   if (BUSY_CHK) begin : g_busy_on
      assign busy_gate = cfg_busy;
   end else begin : g_busy_off
      assign busy_gate = 1'b0;
   end

   cfg_phase_tick #(.HALF(HALF)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ph_clr),
      .last  (ph_last)
   );

   cfg_wait_timer #(.LIMIT(TMO_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tm_clr),
      .count   (tm_cnt),
      .expired (tm_exp)
   );

   cfg_byte_left #(.CNT_W(CNT_W)) u_left (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (byte_count),
      .dec      (cnt_dec),
      .zero     (left_zero)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:     if (start) state_d = ST_PROG;
         ST_PROG:     if (tm_cnt == TW'(PROG_CYC - 1)) state_d = ST_SETTLE;
         ST_SETTLE:   if (!cfg_init && !cfg_busy) state_d = ST_WR_ON;
                      else if (tm_exp)            state_d = ST_FAIL;
         ST_WR_ON:    state_d = ST_CS_ON;
         ST_CS_ON:    state_d = ST_PARK;
         ST_PARK:     state_d = ST_REQ;
         ST_REQ:      if (left_zero)    state_d = ST_CS_OFF;
                      else if (s_valid) state_d = ST_SETUP;
         ST_SETUP:    if (ph_last) state_d = ST_LOW;
         ST_LOW:      if (ph_last) state_d = ST_HIGH;
         ST_HIGH:     if (ph_last) state_d = ST_BSY_CHK;
         ST_BSY_CHK:  if (!busy_gate)  state_d = ST_REQ;
                      else if (tm_exp) state_d = ST_FAIL;
                      else             state_d = ST_STALL_LO;
         ST_STALL_LO: if (ph_last) state_d = ST_STALL_HI;
         ST_STALL_HI: if (ph_last) state_d = ST_BSY_CHK;
         ST_CS_OFF:   state_d = ST_WR_OFF;
         ST_WR_OFF:   state_d = ST_DONE_CHK;
         ST_DONE_CHK: if (cfg_done)    state_d = ST_OK;
                      else if (tm_exp) state_d = ST_FAIL;
                      else             state_d = ST_DONE_LO;
         ST_DONE_LO:  if (ph_last) state_d = ST_DONE_HI;
         ST_DONE_HI:  if (ph_last) state_d = ST_DONE_CHK;
         ST_OK:       state_d = ST_IDLE;
         ST_FAIL:     state_d = ST_IDLE;
         default:     state_d = ST_IDLE;
      endcase
   end

   assign ph_clr   = (state_d != state_q);
   assign tm_clr   = (state_q == ST_IDLE) || (state_q == ST_HIGH) || (state_q == ST_WR_OFF)
                   || (state_q == ST_PROG && state_d == ST_SETTLE);
   assign cnt_load = (state_q == ST_IDLE) && start;
   assign cnt_dec  = (state_q == ST_HIGH) && ph_last;
   assign accept   = (state_q == ST_REQ) && !left_zero && s_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         d_q     <= '0;
      end else begin
         state_q <= state_d;
         if (accept) d_q <= s_data;
      end
   end

   // pin decode
   always_comb begin
      cfg_prog  = (state_q == ST_PROG);
      cfg_abort = (state_q == ST_FAIL);
      load_fail = (state_q == ST_FAIL);
      load_ok   = (state_q == ST_OK);
      s_ready   = (state_q == ST_REQ) && !left_zero;
      unique case (state_q)
         ST_CS_ON, ST_PARK, ST_REQ, ST_SETUP, ST_LOW, ST_HIGH,
         ST_BSY_CHK, ST_STALL_LO, ST_STALL_HI: cfg_cs = 1'b1;
         default:                              cfg_cs = 1'b0;
      endcase
      unique case (state_q)
         ST_WR_ON, ST_CS_ON, ST_PARK, ST_REQ, ST_SETUP, ST_LOW, ST_HIGH,
         ST_BSY_CHK, ST_STALL_LO, ST_STALL_HI, ST_CS_OFF: cfg_wr = 1'b1;
         default:                                        cfg_wr = 1'b0;
      endcase
      unique case (state_q)
         ST_PARK, ST_REQ, ST_SETUP, ST_HIGH, ST_BSY_CHK, ST_STALL_HI,
         ST_CS_OFF, ST_WR_OFF, ST_DONE_CHK, ST_DONE_HI: cfg_clk = 1'b1;
         default:                                      cfg_clk = 1'b0;
      endcase
   end

   assign cfg_d = d_q;
endmodule

// File: rtl/cfg_par_loader_chk.sv
module cfg_par_loader_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_ready,
   input logic              cfg_prog,
   input logic              cfg_cs,
   input logic              cfg_wr,
   input logic              cfg_clk,
   input logic [DATA_W-1:0] cfg_d,
   input logic              cfg_done,
   input logic              cfg_abort,
   input logic              load_ok,
   input logic              load_fail
);
   assert_prog_unframed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_prog |-> (!cfg_cs && !cfg_wr));

   assert_wr_before_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_cs) |-> (cfg_wr && $past(cfg_wr)));

   assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_clk |-> $stable(cfg_d));

   assert_cs_before_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cfg_wr) && !cfg_abort) |-> $past(!cfg_cs));

   assert_ok_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load_ok |-> $past(cfg_done));

   assert_abort_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_abort |-> (load_fail && !cfg_cs && !cfg_wr));

   assert_one_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({load_ok, load_fail}));

   assert_ready_framed_R12: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> (cfg_cs && cfg_wr && cfg_clk));
endmodule

bind cfg_par_loader cfg_par_loader_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/cfg_par_loader_test.sv
module cfg_par_loader_test;
   localparam int HALF = 2;
   localparam int PCYC = 3;
   localparam int TMO  = 40;
   localparam int CW   = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] byte_count = '0;
   logic          s_valid = 1'b0;
   logic [7:0]    s_data = '0;
   logic          s_ready;
   logic          cfg_prog, cfg_cs, cfg_wr, cfg_clk, cfg_abort, load_ok, load_fail;
   logic [7:0]    cfg_d;
   logic          cfg_init = 1'b0;
   logic          cfg_busy = 1'b0;
   logic          cfg_done = 1'b0;

   always #10 clk = ~clk;

   cfg_par_loader #(.CNT_W(CW), .DATA_W(8), .HALF(HALF), .PROG_CYC(PCYC),
                    .TMO_CYC(TMO), .BUSY_CHK(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
      .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
      .cfg_prog(cfg_prog), .cfg_cs(cfg_cs), .cfg_wr(cfg_wr), .cfg_clk(cfg_clk),
      .cfg_d(cfg_d), .cfg_init(cfg_init), .cfg_busy(cfg_busy), .cfg_done(cfg_done),
      .cfg_abort(cfg_abort), .load_ok(load_ok), .load_fail(load_fail));

   int n_vec = 0, n_bad = 0;

   // stream source and port monitors
   logic [7:0] mem [0:15];
   logic [7:0] cap [0:15];
   int  idx = 0, feed_n = 0, cyc = 0;
   bit  gap = 0, pend = 0;
   int  ok_cnt = 0, fail_cnt = 0, abort_bad = 0, prog_rises = 0, prog_len = 0;
   int  wr_rise = 0, cs_rise = 0, cs_fall = 0, wr_fall = 0;
   bit  wr_prev = 0, cs_prev = 0, prog_prev = 0, rdy_seen = 0, rdy_clk = 0;
   bit  in_settle = 0;
   int  settle_cnt = 0, settle_len = 0;
   // target model
   bit  arm_d = 0, arm_e = 0, stall_forever = 0;
   int  ncap = 0, stall_idx = -1, stall_k = 0, stall_left = 0, stall_rises = 0;
   int  done_rises = 0, done_after = 0;

   task automatic chk(bit ok, string tag, int act, int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (pend) idx++;
      s_valid = (idx < feed_n) && !(gap && (cyc % 3 == 0));
      s_data  = (idx < 16) ? mem[idx] : 8'h00;
      pend    = s_ready && s_valid;
      if (load_ok)   ok_cnt++;
      if (load_fail) fail_cnt++;
      if (cfg_abort && (cfg_cs || cfg_wr)) abort_bad++;
      if (cfg_prog) prog_len++;
      if (cfg_prog && !prog_prev) prog_rises++;
      if (!cfg_prog && prog_prev) begin in_settle = 1; settle_cnt = 0; end
      if (in_settle) begin
         if (cfg_abort) begin in_settle = 0; settle_len = settle_cnt; end
         else settle_cnt++;
      end
      if (cfg_wr && !wr_prev) wr_rise = cyc;
      if (!cfg_wr && wr_prev) wr_fall = cyc;
      if (cfg_cs && !cs_prev) cs_rise = cyc;
      if (!cfg_cs && cs_prev) cs_fall = cyc;
      if (s_ready && !rdy_seen) begin rdy_seen = 1; rdy_clk = cfg_clk; end
      wr_prev = cfg_wr; cs_prev = cfg_cs; prog_prev = cfg_prog;
   end

   always @(negedge cfg_clk) begin
      arm_d = cfg_cs && cfg_wr;
      arm_e = !cfg_cs && !cfg_wr;
   end

   always @(posedge cfg_clk) begin
      if (arm_d) begin
         if (!cfg_busy) begin
            cap[ncap % 16] = cfg_d;
            ncap++;
            if (ncap - 1 == stall_idx) begin cfg_busy = 1; stall_left = stall_k; end
         end else begin
            stall_rises++;
            if (stall_left > 0) stall_left--;
            if (stall_left == 0 && !stall_forever) cfg_busy = 0;
         end
      end else if (arm_e) begin
         done_rises++;
         if (done_rises >= done_after) cfg_done = 1;
      end
   end

   task automatic run_load(int n, bit gp, int s_idx, int s_k, bit s_for, int d_after,
                           int settle_delay, bit mid_start, bit exp_ok, string tag);
      int init_low;
      bit mid_done;
      int exp_stall;
      init_low = 0; mid_done = 0;
      for (int i = 0; i < 16; i++) mem[i] = 8'((n * 37 + i * 11 + 5) & 255);
      @(negedge clk);
      idx = 0; pend = 0; feed_n = n + 2; gap = gp;
      ok_cnt = 0; fail_cnt = 0; abort_bad = 0; prog_rises = 0; prog_len = 0;
      wr_rise = 0; cs_rise = 0; cs_fall = 0; wr_fall = 0; rdy_seen = 0; rdy_clk = 0;
      in_settle = 0; settle_len = 0;
      arm_d = 0; arm_e = 0; ncap = 0; stall_idx = s_idx; stall_k = s_k;
      stall_forever = s_for; stall_left = 0; stall_rises = 0;
      done_rises = 0; done_after = d_after; cfg_done = (d_after == 0);
      cfg_busy = 0; cfg_init = (settle_delay > 0);
      byte_count = CW'(n); start = 1;
      @(negedge clk);
      start = 0;
      for (int k = 0; k < 4000; k++) begin
         @(negedge clk);
         start = 0;
         if (settle_delay > 0 && k == settle_delay) begin cfg_init = 0; init_low = cyc; end
         if (mid_start && !mid_done && ncap == 1) begin start = 1; mid_done = 1; end
         if (ok_cnt != 0 || fail_cnt != 0) break;
      end
      start = 0;
      repeat (4) @(negedge clk);
      if (exp_ok) begin
         chk(ok_cnt == 1 && fail_cnt == 0, {tag, " R9 load_ok once"}, ok_cnt, 1);
         chk(ncap == n, {tag, " R5 byte count"}, ncap, n);
         for (int i = 0; i < n; i++)
            chk(cap[i] == mem[i], {tag, " R5 byte value"}, int'(cap[i]), int'(mem[i]));
         chk(idx == n, {tag, " R12 bytes consumed"}, idx, n);
         exp_stall = (s_idx >= 0 && s_idx < n) ? s_k : 0;
         chk(stall_rises == exp_stall, {tag, " R7 stall pulses"}, stall_rises, exp_stall);
         chk(done_rises == d_after, {tag, " R9 done pulses"}, done_rises, d_after);
         chk(cs_rise - wr_rise == 1, {tag, " R4 wr then cs"}, cs_rise - wr_rise, 1);
         if (n > 0) chk(rdy_clk == 1, {tag, " R4 clock parked high"}, int'(rdy_clk), 1);
         chk(wr_fall - cs_fall == 1, {tag, " R8 cs then wr"}, wr_fall - cs_fall, 1);
         chk(prog_rises == 1, {tag, " R2 one program pulse"}, prog_rises, 1);
         chk(prog_len == PCYC, {tag, " R2 program width"}, prog_len, PCYC);
         if (settle_delay > 0)
            chk(wr_rise > init_low, {tag, " R3 wr waits for init"}, wr_rise, init_low + 1);
      end else begin
         chk(fail_cnt == 1 && ok_cnt == 0, {tag, " R10 load_fail once"}, fail_cnt, 1);
         chk(abort_bad == 0, {tag, " R10 abort with framing released"}, abort_bad, 0);
         chk(!cfg_cs && !cfg_wr, {tag, " R10 idle after abort"}, int'(cfg_cs | cfg_wr), 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk({s_ready, cfg_prog, cfg_cs, cfg_wr, cfg_clk, cfg_abort, load_ok, load_fail} == 8'h00
          && cfg_d == 8'h00, "R1 outputs in reset", int'(cfg_d), 0);
      rst_n = 1;
      repeat (3) @(negedge clk);
      chk({s_ready, cfg_prog, cfg_cs, cfg_wr, cfg_clk, cfg_abort, load_ok, load_fail} == 8'h00,
          "R1 idle after reset", int'({cfg_prog, cfg_cs, cfg_wr, cfg_clk}), 0);

      // settle never reached: exact timeout distance
      run_load(2, 0, -1, 0, 0, 1, 9999, 0, 0, "settle_tmo");
      chk(prog_len == PCYC, "R2 program width before timeout", prog_len, PCYC);
      chk(settle_len == TMO + 1, "R10 settle timeout distance", settle_len, TMO + 1);
      cfg_init = 0;

      for (int n = 1; n <= 6; n++)
         for (int g = 0; g < 2; g++)
            run_load(n, bit'(g), -1, 0, 0, n % 3, 0, 0, 1, "sweep");

      run_load(3, 0, -1, 0, 0, 2, 10, 0, 1, "late_settle");
      run_load(4, 1, 1, 3, 0, 1, 0, 0, 1, "stall_mid R7");
      run_load(2, 0, 1, 2, 0, 0, 0, 0, 1, "stall_last R7");
      run_load(3, 0, 0, 0, 1, 0, 0, 0, 0, "stall_tmo");
      cfg_busy = 0;
      run_load(2, 0, -1, 0, 0, 1000, 0, 0, 0, "done_tmo");
      run_load(0, 0, -1, 0, 0, 1, 0, 0, 1, "zero R11");
      run_load(5, 0, -1, 0, 0, 1, 0, 1, 1, "mid_start R2");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule